// File: doc/BRIEF.md
# Segmented Address Extension and Protection Unit

This block sits on one core's memory request path. It turns each 32-bit logical address into a 36-bit physical address and checks that the access is allowed. The mapping comes from a bank of sixteen programmable segment descriptors. Each descriptor has a high word and a low word. A descriptor covers a naturally aligned power-of-two window, from 4 KB up to the whole 4 GB space. It places that window anywhere in the 36-bit physical space. It also grants read, write and execute rights separately for user mode and supervisor mode.

A request carries an address, an access kind and a mode flag. One cycle later the block returns:
- a response valid,
- the translated address,
- a hit flag, which is set when any enabled segment covers the address,
- a fault flag, which is set when no segment covers the address or when the selected segment does not grant the needed right.

Software programs the descriptors through a simple word-wide write and read port. Out of reset, two segments map the whole logical space: the lower half maps onto itself and the upper half maps into the physical region at 0x8_0000_0000.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, the descriptor words read back as follows. Segment 0: high word 0x0000_001E, low word 0x0000_003F. Segment 1: high word 0x8000_001E, low word 0x8000_003F. Every other word reads 0.
- R2: `cfg_sel` = {segment index, word}, where word 0 is the high word and word 1 is the low word. A write with `cfg_wr` lands on the next edge. `cfg_rdata` shows the selected word without a clock edge. In the high word, bits 31:12 are the logical base and bits 4:0 are the size code. In the low word, bits 31:8 are the physical replacement base (physical bits 35:12) and bits 5:0 are the rights. All other bits read back as 0.
- R3: A size code c of 0x0B or more enables a segment of 2^(c+1) bytes. The segment covers an address when address bits [31:c+1] equal the same bits of the base. A code below 0x0B disables the segment, so it never covers any address.
- R4: On a hit, the physical address takes bits [35:c+1] from the replacement base, and logical bits [c:0] pass through unchanged.
- R5: Rights bits, counted from bit 0: user execute, user write, user read, supervisor execute, supervisor write, supervisor read. `req_kind` is 0 for read, 1 for write and 2 for execute. `req_user` = 1 selects user mode. A hit without the matching right returns `rsp_hit` = 1, the translated address, and `rsp_fault` = 1.
- R6: When no enabled segment covers the address, the response has `rsp_hit` = 0, `rsp_fault` = 1 and `rsp_addr` = 0.
- R7: When several segments cover the address, the segment with the highest index supplies the translation and the rights.
- R8: The response valid follows the request valid by exactly one cycle. The hit and fault flags are 0 on cycles with no valid response.
- R9: `req_kind` = 3 is reserved and always faults.
- R10: Size code 0x1F covers all 4 GB regardless of the base field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Logical address |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| cfg_wr | input | 1 | Descriptor word write strobe |
| cfg_sel | input | 5 | {segment index, word select} |
| cfg_wdata | input | 32 | Descriptor write data |
| cfg_rdata | output | 32 | Selected descriptor word |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_addr | output | 36 | Physical address |
| rsp_hit | output | 1 | A segment covered the address |
| rsp_fault | output | 1 | Miss or missing right |

## Verification
The bench steps one segment through every size code. At each code it probes the last byte inside the window, the first byte past it, and the byte just below the base:
- an off-by-one in the size decode would make the window twice or half its proper size;
- a wrong pass-through mask would corrupt the offset bits.

It sweeps all 64 rights patterns against every kind and mode. This catches a swapped bit order, which would grant a write where only a read was allowed. It overlaps segments to check that the highest index wins; a resolver that picked the lowest index would return the wrong physical region. It also disables the two reset segments to check that a miss faults with a zero address.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int LA_W   = 32;
    localparam int PA_W   = 36;
    localparam int PG_W   = 12;
    localparam int BASE_W = LA_W - PG_W;
    localparam int REPL_W = PA_W - PG_W;
    localparam int CODE_W = 5;
    localparam int PERM_W = 6;
    localparam logic [CODE_W-1:0] MIN_CODE = 5'h0B;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [CODE_W-1:0] code;
    } seg_hi_t;

    typedef struct packed {
        logic [REPL_W-1:0] repl;
        logic [PERM_W-1:0] perm;
    } seg_lo_t;

    typedef struct packed {
        seg_hi_t hi;
        seg_lo_t lo;
    } seg_desc_t;

    typedef struct packed {
        logic            valid;
        logic            hit;
        logic            fault;
        logic [PA_W-1:0] addr;
    } xlate_rsp_t;

    function automatic logic code_on(input logic [CODE_W-1:0] c);
        return c >= MIN_CODE;
    endfunction

    // page-granular bits that must equal the base for a hit
    function automatic logic [BASE_W-1:0] keep_mask(input logic [CODE_W-1:0] c);
        logic [BASE_W-1:0] m;
        for (int i = 0; i < BASE_W; i++) m[i] = (i + PG_W) > int'(c);
        return m;
    endfunction

    // physical bits taken from the logical address
    function automatic logic [PA_W-1:0] pass_mask(input logic [CODE_W-1:0] c);
        logic [PA_W-1:0] m;
        for (int i = 0; i < PA_W; i++) m[i] = i <= int'(c);
        return m;
    endfunction

    function automatic logic [2:0] perm_sel(input acc_kind_e k, input logic user);
        logic [2:0] off;
        case (k)
            ACC_READ:  off = 3'd2;
            ACC_WRITE: off = 3'd1;
            default:   off = 3'd0;
        endcase
        return (user ? 3'd0 : 3'd3) + off;
    endfunction

    function automatic seg_desc_t reset_desc(input int s);
        seg_desc_t d;
        d = '0;
        if (s == 0) begin
            d.hi.code = 5'h1E;
            d.lo.perm = '1;
        end else if (s == 1) begin
            d.hi.base = 20'h80000;
            d.hi.code = 5'h1E;
            d.lo.repl = 24'h800000;
            d.lo.perm = '1;
        end
        return d;
    endfunction

endpackage

// File: rtl/seg_desc_bank.sv
module seg_desc_bank
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_wr,
    input  logic [$clog2(NUM_SEG):0]    cfg_sel,
    input  logic [31:0]                 cfg_wdata,
    output logic [31:0]                 cfg_rdata,
    output seg_desc_t                   desc_o [NUM_SEG]
);
    localparam int IDX_W = $clog2(NUM_SEG);

    seg_desc_t        regs [NUM_SEG];
    seg_desc_t        cur;
    logic [IDX_W-1:0] sel_idx;

    assign sel_idx = cfg_sel[IDX_W:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SEG; s++) regs[s] <= reset_desc(s);
        end else if (cfg_wr) begin
            if (cfg_sel[0])
                regs[sel_idx].lo <= '{repl: cfg_wdata[31:8], perm: cfg_wdata[PERM_W-1:0]};
            else
                regs[sel_idx].hi <= '{base: cfg_wdata[31:PG_W], code: cfg_wdata[CODE_W-1:0]};
        end
    end

    always_comb begin
        cur = regs[sel_idx];
        if (cfg_sel[0])
            cfg_rdata = {cur.lo.repl, 2'b00, cur.lo.perm};
        else
            cfg_rdata = {cur.hi.base, 7'b0, cur.hi.code};
    end

    assign desc_o = regs;

    // R1: the two boot windows exist right after reset
    a_r1_boot_windows: assert property (@(posedge clk)
        $past(rst) && !rst |-> desc_o[0].hi.code == 5'h1E && desc_o[1].lo.repl == 24'h800000);

endmodule

// File: rtl/seg_match_slice.sv
module seg_match_slice
    import seg_xlate_pkg::*;
(
    input  seg_desc_t         desc_i,
    input  logic [LA_W-1:0]   addr_i,
    output logic              match_o,
    output logic [PA_W-1:0]   phys_o
);
    logic [BASE_W-1:0] keep;
    logic [PA_W-1:0]   pass;

    always_comb begin
        keep    = keep_mask(desc_i.hi.code);
        pass    = pass_mask(desc_i.hi.code);
        match_o = code_on(desc_i.hi.code) &&
                  (((addr_i[LA_W-1:PG_W] ^ desc_i.hi.base) & keep) == '0);
        phys_o  = ({desc_i.lo.repl, {PG_W{1'b0}}} & ~pass) |
                  ({{(PA_W-LA_W){1'b0}}, addr_i} & pass);
    end

endmodule

// File: rtl/seg_resolve.sv
module seg_resolve
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic               req_user,
    input  logic [NUM_SEG-1:0] match_i,
    input  logic [PA_W-1:0]    phys_i [NUM_SEG],
    input  logic [PERM_W-1:0]  perm_i [NUM_SEG],
    output xlate_rsp_t         rsp_o
);
    logic              win_hit;
    logic [PA_W-1:0]   win_phys;
    logic [PERM_W-1:0] win_perm;
    acc_kind_e         kind;
    logic              allowed;
    xlate_rsp_t        rsp_d;

    // ascending scan: the last (highest) matching index wins
    always_comb begin
        win_hit  = 1'b0;
        win_phys = '0;
        win_perm = '0;
        for (int s = 0; s < NUM_SEG; s++) begin
            if (match_i[s]) begin
                win_hit  = 1'b1;
                win_phys = phys_i[s];
                win_perm = perm_i[s];
            end
        end
        kind    = acc_kind_e'(req_kind);
        allowed = (kind != ACC_RSVD) && win_perm[perm_sel(kind, req_user)];
        rsp_d.valid = req_valid;
        rsp_d.hit   = req_valid && win_hit;
        rsp_d.fault = req_valid && !(win_hit && allowed);
        rsp_d.addr  = (req_valid && win_hit) ? win_phys : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_o <= '0;
        else     rsp_o <= rsp_d;
    end

    // R9: reserved access kind never passes
    a_r9_rsvd_faults: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == 2'b11 |=> rsp_o.fault);

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [31:0]              req_addr,
    input  logic [1:0]               req_kind,
    input  logic                     req_user,
    input  logic                     cfg_wr,
    input  logic [$clog2(NUM_SEG):0] cfg_sel,
    input  logic [31:0]              cfg_wdata,
    output logic [31:0]              cfg_rdata,
    output logic                     rsp_valid,
    output logic [35:0]              rsp_addr,
    output logic                     rsp_hit,
    output logic                     rsp_fault
);
    seg_desc_t          desc   [NUM_SEG];
    logic [NUM_SEG-1:0] match;
    logic [PA_W-1:0]    phys   [NUM_SEG];
    logic [PERM_W-1:0]  perm   [NUM_SEG];
    xlate_rsp_t         rsp;

    seg_desc_bank #(.NUM_SEG(NUM_SEG)) bank_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .desc_o    (desc)
    );

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_slice
        seg_match_slice slice_i (
            .desc_i  (desc[s]),
            .addr_i  (req_addr),
            .match_o (match[s]),
            .phys_o  (phys[s])
        );
        assign perm[s] = desc[s].lo.perm;
    end

    seg_resolve #(.NUM_SEG(NUM_SEG)) resolve_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_user  (req_user),
        .match_i   (match),
        .phys_i    (phys),
        .perm_i    (perm),
        .rsp_o     (rsp)
    );

    assign rsp_valid = rsp.valid;
    assign rsp_addr  = rsp.addr;
    assign rsp_hit   = rsp.hit;
    assign rsp_fault = rsp.fault;

    // R8: one-cycle response
    a_r8_latency: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R8: quiet when no request
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !rsp_hit && !rsp_fault);
    // R4: page offset always passes through on a hit
    a_r4_offset_pass: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_hit |-> rsp_addr[PG_W-1:0] == $past(req_addr[PG_W-1:0]));
    // R6: a miss faults with a zero address
    a_r6_miss_fault: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit |-> rsp_fault && rsp_addr == '0);

endmodule

// File: tb/seg_xlate_unit_tb_top.sv
module seg_xlate_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        rsp_valid;
    logic [35:0] rsp_addr;
    logic        rsp_hit;
    logic        rsp_fault;

    always #10 clk = ~clk;

    seg_xlate_unit dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .req_user(req_user), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_hit(rsp_hit),
        .rsp_fault(rsp_fault)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] mhi [16];
    logic [31:0] mlo [16];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] a, input int kind, input bit user,
                                  output logic hit, output logic flt, output logic [35:0] pa);
        int win;
        int n;
        logic [63:0] r;
        win = -1;
        for (int s = 0; s < 16; s++) begin
            if (mhi[s][4:0] >= 5'h0B) begin
                n = int'(mhi[s][4:0]) + 1;
                if ((64'(a) >> n) == (64'({mhi[s][31:12], 12'h000}) >> n)) win = s;
            end
        end
        hit = 0; flt = 1; pa = '0;
        if (win >= 0) begin
            hit = 1;
            n = int'(mhi[win][4:0]) + 1;
            r = 64'(mlo[win][31:8]) << 12;
            r = ((r >> n) << n) | (64'(a) & ((64'd1 << n) - 64'd1));
            pa = r[35:0];
            if (kind != 3)
                flt = !mlo[win][(user ? 0 : 3) + (kind == 0 ? 2 : (kind == 1 ? 1 : 0))];
        end
    endfunction

    task automatic wr(input int seg, input bit lo, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_sel = {seg[3:0], lo}; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
        if (lo) mlo[seg] = d & 32'hFFFF_FF3F;
        else    mhi[seg] = d & 32'hFFFF_F01F;
    endtask

    task automatic rd(input int seg, input bit lo, input string req);
        @(negedge clk);
        cfg_sel = {seg[3:0], lo};
        #1;
        chk(req, 64'(cfg_rdata), 64'(lo ? mlo[seg] : mhi[seg]));
    endtask

    task automatic xreq(input logic [31:0] a, input int kind, input bit user, input string req);
        logic h, f;
        logic [35:0] pa;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_kind = kind[1:0]; req_user = user;
        @(negedge clk);
        req_valid = 0;
        model(a, kind, user, h, f, pa);
        chk(req, {25'd0, rsp_valid, rsp_hit, rsp_fault, rsp_addr}, {25'd0, 1'b1, h, f, pa});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] top;
        for (int s = 0; s < 16; s++) begin mhi[s] = '0; mlo[s] = '0; end
        mhi[0] = 32'h0000_001E; mlo[0] = 32'h0000_003F;
        mhi[1] = 32'h8000_001E; mlo[1] = 32'h8000_003F;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 / R8: quiet outputs after reset
        chk("R1", {61'd0, rsp_valid, rsp_hit, rsp_fault}, 64'd0);
        for (int s = 0; s < 16; s++) begin
            rd(s, 0, "R1");
            rd(s, 1, "R1");
        end

        // R4: boot windows
        xreq(32'h1234_5678, 0, 0, "R4");
        xreq(32'h9000_0010, 2, 1, "R4");
        xreq(32'h7FFF_FFFF, 1, 0, "R3");
        @(negedge clk);
        chk("R8", {61'd0, rsp_valid, rsp_hit, rsp_fault}, 64'd0);

        // R7: 1 MB window overlapping segment 1
        wr(3, 0, 32'h8810_0013);
        wr(3, 1, 32'h00C0_003F);
        rd(3, 0, "R2");
        rd(3, 1, "R2");
        xreq(32'h8810_0000, 0, 0, "R7");
        xreq(32'h881F_FFFC, 1, 1, "R4");
        xreq(32'h8820_0000, 0, 0, "R7");

        // R2 reserved bits, R10 whole-space segment with no rights
        wr(5, 0, 32'hFFFF_FFFF);
        rd(5, 0, "R2");
        wr(5, 1, 32'hFFFF_FFC0);
        rd(5, 1, "R2");
        xreq(32'h0000_1000, 0, 0, "R10");
        xreq(32'h8810_0004, 2, 1, "R10");
        wr(5, 0, 32'h0);
        wr(5, 1, 32'h0);

        // R5 / R9: every rights pattern, kind and mode
        wr(2, 0, 32'h2100_000B);
        for (int p = 0; p < 64; p++) begin
            wr(2, 1, 32'h1000_0000 | p);
            for (int u = 0; u < 2; u++)
                for (int k = 0; k < 4; k++)
                    xreq(32'h2100_0ABC, k, u[0], (k == 3) ? "R9" : "R5");
        end

        // R6 miss, R3 disabled code
        wr(0, 0, 32'h0);
        wr(1, 0, 32'h0);
        xreq(32'h0000_0000, 0, 0, "R6");
        xreq(32'hC000_0040, 2, 0, "R6");
        wr(4, 0, 32'h4000_000A);
        wr(4, 1, 32'hFFFF_FF3F);
        xreq(32'h4000_0000, 0, 0, "R3");

        // R3 / R4 / R10: size sweep at window edges
        wr(6, 1, 32'hA000_003F);
        for (int c = 11; c < 32; c++) begin
            wr(6, 0, 32'h8000_0000 | c);
            top = 64'h8000_0000 + (64'd1 << (c + 1));
            xreq(32'(top - 64'd1), 0, 0, "R3");
            xreq(top[31:0], 0, 0, (c == 31) ? "R10" : "R3");
            xreq(32'h7FFF_FFFF, 0, 0, "R3");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule